// File: doc/BRIEF.md
# Infrared Carrier Burst Timer

This block produces the on/off envelope of an infrared remote-control transmission. A 9-bit down counter is loaded from a CPU-side write strobe. While the counter holds a nonzero value, the transmit output is active. It is active either as a gated square-wave carrier or as a steady high level. The counter decrements once per prescaled tick, stops at zero and reports that it has expired with a one-cycle pulse.

A small control register chooses between the carrier and the steady level. It also chooses whether the shared indicator pin is driven as an output. When driven, that pin is an active-low transmission indicator: it is high while idle and low while a burst is in progress. Firmware builds a complete frame by loading one counter value after another. A write during a burst reloads the counter without disturbing the carrier phase.

Top module: `irBurstTimer`

## Requirements
- R1: After reset, the count is 0, remOut is low, ledOut is high, ledOe is high and doneOut is low. The control register resets to 0.
- R2: A write on wrCount loads wrData into the count in the next cycle. While the count is nonzero, it drops by one every TICK_DIV cycles, counted from the cycle in which the load becomes visible. It then holds at 0.
- R3: A write of zero while idle leaves the count at 0 and remOut low.
- R4: With control bit 2 clear, remOut follows the carrier while the count is nonzero. The carrier is high for CAR_HI cycles and then low for CAR_LO cycles, repeating. It starts with its high phase in the first cycle after a load from idle.
- R5: With control bit 2 set, remOut is a constant high while the count is nonzero.
- R6: remOut is low in every cycle in which the count is 0.
- R7: doneOut is high for exactly one cycle: the first cycle in which the count reads 0 after it has counted down from 1. A zero write does not raise it.
- R8: ledOut is low while the count is nonzero and high while it is 0.
- R9: ledOe equals the inverse of control bit 3. Setting bit 3 releases the indicator pin for use as a sense input.
- R10: A nonzero write during a burst loads the new count in the next cycle and restarts the tick prescaler. The carrier phase continues without interruption.
- R11: A zero write during a burst stops the timer in the next cycle. remOut goes low and doneOut stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrCount | input | 1 | Counter write strobe |
| wrData | input | 9 | Counter load value |
| wrCtrl | input | 1 | Control register write strobe |
| ctrlData | input | 4 | Control value (bit 2: carrier off, bit 3: indicator released) |
| countOut | output | 9 | Current counter value |
| remOut | output | 1 | Transmit output |
| ledOut | output | 1 | Active-low transmission indicator |
| ledOe | output | 1 | Indicator output enable |
| doneOut | output | 1 | One-cycle expiry pulse |

## Verification
Short loads with the carrier on show whether the carrier's high and low phases line up with the prescaled ticks and the burst length. Loads with the carrier off separate the steady-level path from the gated path. A reload in mid-burst shows the difference between restarting the prescaler and keeping the carrier phase running. A zero write in mid-burst shows the difference between a forced stop and a natural expiry, which is the only case that may pulse done. A full-scale load of 511 exercises the top counter bit and the long hold at zero afterwards.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef struct packed {
    logic load;   // nonzero value written to the counter
    logic stop;   // zero written to the counter
    logic tick;   // prescaled decrement
  } irStrobe_t;

  localparam int CARRIER_OFF_BIT = 2;
  localparam int LED_REL_BIT     = 3;
endpackage

// File: rtl/irtx_ctrl.sv
module irtx_ctrl
  import irtx_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int TICK_DIV = 4,
  parameter int CAR_HI   = 2,
  parameter int CAR_LO   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCount,
  input  logic [CNT_W-1:0] wrData,
  input  logic             running,
  output irStrobe_t        strobe,
  output logic             carrierOn
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam int PER   = CAR_HI + CAR_LO;
  localparam int PH_W  = $clog2(PER + 1);

  logic [PRE_W-1:0] preCnt;
  logic [PH_W-1:0]  carPh;
  logic             preWrap;

  assign preWrap      = (preCnt == PRE_W'(TICK_DIV - 1));
  assign strobe.load  = wrCount && (wrData != '0);
  assign strobe.stop  = wrCount && (wrData == '0);
  assign strobe.tick  = running && !wrCount && preWrap;
  assign carrierOn    = (carPh < PH_W'(CAR_HI));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobe.load || !running || preWrap) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // Carrier phase runs freely during a burst, so a reload never cuts a period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carPh <= '0;
    end else if (!running) begin
      carPh <= '0;
    end else if (carPh == PH_W'(PER - 1)) begin
      carPh <= '0;
    end else begin
      carPh <= carPh + 1'b1;
    end
  end

  a_r4_phase_range: assert property (@(posedge clk) disable iff (!rstN)
    carPh < PH_W'(PER));
  a_r2_tick_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |-> running);
  a_r4_restart_high: assert property (@(posedge clk) disable iff (!rstN)
    (!running && strobe.load) |=> carrierOn);
endmodule

// File: rtl/irtx_dp.sv
module irtx_dp
  import irtx_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  irStrobe_t         strobe,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              wrCtrl,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              carrierOn,
  output logic              running,
  output logic [CNT_W-1:0]  countOut,
  output logic              remOut,
  output logic              ledOut,
  output logic              ledOe,
  output logic              doneOut
);
  logic [CNT_W-1:0]  count;
  logic [CTRL_W-1:0] ctrlReg;

  assign running  = (count != '0);
  assign countOut = count;
  assign remOut   = running && (ctrlReg[CARRIER_OFF_BIT] || carrierOn);
  assign ledOut   = !running;
  assign ledOe    = !ctrlReg[LED_REL_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= strobe.tick && (count == CNT_W'(1));
      if (strobe.load || strobe.stop) begin
        count <= wrData;
      end else if (strobe.tick) begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= ctrlData;
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load || strobe.stop) |=> count == $past(wrData));
  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !strobe.load) |=> count == '0);
  a_r6_rem_idle: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> !remOut);
  a_r7_done_origin: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (count == '0 && $past(count) == CNT_W'(1)));
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stop |=> !doneOut);
endmodule

// File: rtl/irBurstTimer.sv
module irBurstTimer
  import irtx_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int CTRL_W   = 4,
  parameter int TICK_DIV = 4,
  parameter int CAR_HI   = 2,
  parameter int CAR_LO   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCount,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              wrCtrl,
  input  logic [CTRL_W-1:0] ctrlData,
  output logic [CNT_W-1:0]  countOut,
  output logic              remOut,
  output logic              ledOut,
  output logic              ledOe,
  output logic              doneOut
);
  irStrobe_t strobe;
  logic      running;
  logic      carrierOn;

  irtx_ctrl #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .CAR_HI(CAR_HI), .CAR_LO(CAR_LO)) uCtrl (
    .clk(clk), .rstN(rstN), .wrCount(wrCount), .wrData(wrData),
    .running(running), .strobe(strobe), .carrierOn(carrierOn)
  );

  irtx_dp #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wrCtrl(wrCtrl), .ctrlData(ctrlData), .carrierOn(carrierOn),
    .running(running), .countOut(countOut), .remOut(remOut),
    .ledOut(ledOut), .ledOe(ledOe), .doneOut(doneOut)
  );
endmodule

// File: tb/irBurstTimer_test.sv
`timescale 1ns/1ps
module irBurstTimer_test;
  localparam int DIV = 4;
  localparam int HI  = 2;
  localparam int LO  = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrCount = 1'b0;
  logic [8:0] wrData = '0;
  logic       wrCtrl = 1'b0;
  logic [3:0] ctrlData = '0;
  logic [8:0] countOut;
  logic       remOut, ledOut, ledOe, doneOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  int mCount = 0, mPre = 0, mPh = 0, mCtrl = 0;
  bit mDone = 0;

  irBurstTimer uut (
    .clk(clk), .rstN(rstN), .wrCount(wrCount), .wrData(wrData),
    .wrCtrl(wrCtrl), .ctrlData(ctrlData), .countOut(countOut),
    .remOut(remOut), .ledOut(ledOut), .ledOe(ledOe), .doneOut(doneOut)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCount = 0; mPre = 0; mPh = 0; mCtrl = 0; mDone = 0;
    end else begin
      bit run, tick;
      run  = (mCount != 0);
      tick = run && !wrCount && (mPre == DIV - 1);
      mDone = tick && (mCount == 1);
      if ((wrCount && wrData != 0) || !run || mPre == DIV - 1) mPre = 0;
      else mPre++;
      mPh = run ? ((mPh + 1) % (HI + LO)) : 0;
      if (wrCount) mCount = wrData;
      else if (tick) mCount--;
      if (wrCtrl) mCtrl = ctrlData;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit run, expRem;
      run = (mCount != 0);
      expRem = run && (((mCtrl >> 2) & 1) != 0 || mPh < HI);
      chk(countOut == mCount, "R2 count", countOut, mCount);
      chk(remOut == expRem, (mCtrl & 4) != 0 ? "R5 rem" : (run ? "R4 rem" : "R6 rem"),
          remOut, expRem);
      chk(ledOut == !run, "R8 led", ledOut, !run);
      chk(ledOe == ((mCtrl & 8) == 0), "R9 ledOe", ledOe, (mCtrl & 8) == 0);
      chk(doneOut == mDone, "R7 done", doneOut, mDone);
    end
  end

  task automatic putCount(input int v);
    @(negedge clk); wrCount = 1'b1; wrData = 9'(v);
    @(negedge clk); wrCount = 1'b0;
  endtask

  task automatic putCtrl(input int v);
    @(negedge clk); wrCtrl = 1'b1; ctrlData = 4'(v);
    @(negedge clk); wrCtrl = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(countOut == 0 && !remOut && ledOut && ledOe && !doneOut, "R1 reset",
        {countOut, remOut, ledOut, ledOe, doneOut}, 6);
    putCount(3); idle(20);
    putCount(0);
    chk(countOut == 0 && !remOut, "R3 zero idle", countOut, 0);
    idle(4);
    putCtrl(4); putCount(2); idle(12);
    putCtrl(0);
    @(negedge clk); wrCount = 1'b1; wrData = 9'd5;
    @(negedge clk); wrCount = 1'b0;
    idle(6);
    @(negedge clk); wrCount = 1'b1; wrData = 9'd2;
    @(negedge clk); wrCount = 1'b0;
    chk(countOut == 2, "R10 reload", countOut, 2);
    idle(15);
    putCount(4); idle(5);
    @(negedge clk); wrCount = 1'b1; wrData = 9'd0;
    @(negedge clk); wrCount = 1'b0;
    chk(countOut == 0 && !remOut && !doneOut, "R11 forced stop", countOut, 0);
    idle(3);
    putCtrl(8);
    chk(!ledOe, "R9 release", ledOe, 0);
    putCtrl(0); putCount(511); idle(2100);
    chk(countOut == 0 && ledOut, "R2 full scale expiry", countOut, 0);
    finishRun();
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    finishRun();
  end
endmodule